// File: doc/BRIEF.md
# Receiver AGC Lock Controller

This block closes the digital side of a receive gain loop. It watches the signed samples coming from the A/D converter in fixed windows. In each window it counts the samples that sit at the full-scale code and records the peak magnitude. From these two figures it decides at the end of every window whether to add attenuation, remove attenuation or declare lock. When saturation is heavy, it adds attenuation in large steps. When the overload is mild, it uses small steps.

Once the peak falls inside a programmable window and no sample saturates, the controller locks. It then freezes the attenuation code and the coarse pad for the rest of the packet, and it raises a one-cycle carrier-sense pulse. While locked, the controller keeps measuring. If the peak moves away from the level it locked on by more than a programmable limit, it drops lock and adjustment resumes.

An external comparator input can engage a coarse 30 dB pad. The controller accepts this input only while it is unlocked. Accepting it also preloads the attenuation accumulator with a programmed value.

Top module: `rx_agc_lock_ctrl`

## Requirements
- R1: After reset, gain_atten is 0 (highest gain), pad_on is 0, agc_locked is 0 and cs_pulse is 0.
- R2: A window is WIN (default 32) accepted samples, a sample being accepted on a clock edge with smp_valid high. A sample counts as saturated when its magnitude is the largest code, which is +127 or -128 at 8 bits. The window peak is the largest magnitude seen, with -128 taken as 127.
- R3: While unlocked, a window with a saturated count of at least cfg_heavy_thr (and not zero) raises gain_atten by STEP_BIG (default 8).
- R4: While unlocked, a window with a saturated count between 1 and cfg_heavy_thr-1 raises gain_atten by STEP_SMALL (default 2). A window with no saturation but a peak above cfg_win_hi does the same.
- R5: While unlocked, a window with no saturation and a peak below cfg_win_lo lowers gain_atten by STEP_SMALL.
- R6: While unlocked, a window with no saturation and cfg_win_lo <= peak <= cfg_win_hi (both bounds inclusive) sets agc_locked. It leaves gain_atten unchanged and raises cs_pulse for exactly one cycle, in the cycle in which agc_locked rises.
- R7: While locked, gain_atten does not change. Lock is dropped only after a window whose peak differs from the peak recorded at lock by more than cfg_unlock_delta. A difference equal to the limit keeps lock.
- R8: While unlocked and rx_en is high, pad_det high sets pad_on, loads gain_atten with cfg_pad_preset, keeps agc_locked at 0 and restarts the current window. pad_on then stays set until rx_en falls.
- R9: While locked, pad_det has no effect: pad_on, gain_atten and agc_locked keep their values.
- R10: gain_atten saturates at 0 and at its largest code (63 for a 6-bit code) and never wraps.
- R11: With rx_en low, gain_atten returns to 0, pad_on and agc_locked clear, and samples are ignored. A window starts fresh once rx_en returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable; low returns the loop to its home state |
| smp_valid | input | 1 | A/D sample strobe |
| smp_data | input | ADC_W | Signed A/D sample |
| pad_det | input | 1 | Coarse pad request from the RF comparator |
| cfg_win_lo | input | ADC_W-1 | Lower bound of the lock window (peak magnitude) |
| cfg_win_hi | input | ADC_W-1 | Upper bound of the lock window (peak magnitude) |
| cfg_heavy_thr | input | clog2(WIN+1) | Saturated-sample count that selects the large step |
| cfg_unlock_delta | input | ADC_W-1 | Largest peak drift tolerated while locked |
| cfg_pad_preset | input | ATT_W | Attenuation loaded when the pad engages |
| gain_atten | output | ATT_W | Attenuation code, 0 = maximum gain |
| pad_on | output | 1 | Coarse pad enable |
| agc_locked | output | 1 | Lock flag |
| cs_pulse | output | 1 | One-cycle pulse on each lock event |

## Verification
The bench builds the block with its defaults: 8-bit samples, a 6-bit attenuation code, 32-sample windows, steps of 8 and 2, and the two-level step variant. The 6-bit code lets a handful of heavy windows started from the pad preset of 30 reach the upper clamp at 63. The same 8-bit width puts both full-scale codes, +127 and -128, in the stimulus. The configured window of 40 to 90, heavy threshold of 8 and drift limit of 20 are each hit exactly, so every inclusive and exclusive comparison is tested at its edge.

// File: rtl/agc_pkg.sv
package agc_pkg;

   // Decision taken at the end of a measurement window
   typedef enum logic [1:0] {
      ACT_HOLD     = 2'd0,
      ACT_ATT_UP   = 2'd1,
      ACT_ATT_DOWN = 2'd2,
      ACT_LOCK     = 2'd3
   } agc_act_e;

endpackage

// File: rtl/agc_window_meter.sv
module agc_window_meter #(
   parameter  int ADC_W = 8,
   parameter  int WIN   = 32,
   localparam int MAG_W = ADC_W - 1,
   localparam int CNT_W = $clog2(WIN + 1),
   localparam int IDX_W = $clog2(WIN)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr,
   input  logic                    smp_valid,
   input  logic signed [ADC_W-1:0] smp_data,
   output logic                    done_q,
   output logic [CNT_W-1:0]        sat_q,
   output logic [MAG_W-1:0]        peak_q
);

   localparam logic [MAG_W-1:0] MAG_MAX = '1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WIN - 1);

   logic [MAG_W-1:0] mag;
   logic             full_scale;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] sat_acc_q;
   logic [MAG_W-1:0] peak_acc_q;
   logic [CNT_W-1:0] sat_nxt;
   logic [MAG_W-1:0] peak_nxt;

   // Magnitude with the most negative code folded onto the positive maximum
   always_comb begin
      if (smp_data[ADC_W-1]) begin
         if (smp_data[ADC_W-2:0] == '0) begin
            mag = MAG_MAX;
         end else begin
            mag = MAG_W'(-smp_data);
         end
      end else begin
         mag = smp_data[MAG_W-1:0];
      end
      full_scale = (mag == MAG_MAX);
      sat_nxt    = sat_acc_q + CNT_W'(full_scale);
      peak_nxt   = (mag > peak_acc_q) ? mag : peak_acc_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q      <= '0;
         sat_acc_q  <= '0;
         peak_acc_q <= '0;
         done_q     <= 1'b0;
         sat_q      <= '0;
         peak_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (clr) begin
            idx_q      <= '0;
            sat_acc_q  <= '0;
            peak_acc_q <= '0;
         end else if (smp_valid) begin
            if (idx_q == IDX_LAST) begin
               done_q     <= 1'b1;
               sat_q      <= sat_nxt;
               peak_q     <= peak_nxt;
               idx_q      <= '0;
               sat_acc_q  <= '0;
               peak_acc_q <= '0;
            end else begin
               idx_q      <= idx_q + 1'b1;
               sat_acc_q  <= sat_nxt;
               peak_acc_q <= peak_nxt;
            end
         end
      end
   end

   AST_SAT_MEANS_FULL_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && sat_q != '0) |-> peak_q == MAG_MAX); // R2
   AST_DONE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R2

endmodule

// File: rtl/agc_step_sel.sv
module agc_step_sel
   import agc_pkg::*;
#(
   parameter  int ADC_W      = 8,
   parameter  int WIN        = 32,
   parameter  int ATT_W      = 6,
   parameter  int STEP_BIG   = 8,
   parameter  int STEP_SMALL = 2,
   parameter  int ADAPT_STEP = 0,
   parameter  int SAT_SHIFT  = 2,
   localparam int MAG_W      = ADC_W - 1,
   localparam int CNT_W      = $clog2(WIN + 1)
) (
   input  logic [CNT_W-1:0] sat_cnt,
   input  logic [MAG_W-1:0] peak,
   input  logic [MAG_W-1:0] cfg_win_lo,
   input  logic [MAG_W-1:0] cfg_win_hi,
   input  logic [CNT_W-1:0] cfg_heavy_thr,
   output agc_act_e         act,
   output logic [ATT_W-1:0] step
);

   logic [ATT_W-1:0] big_step;

   generate
      if (ADAPT_STEP == 0) begin : g_two_level
         assign big_step = ATT_W'(STEP_BIG);
      end else begin : g_scaled
         // large step grows with the number of saturated samples
         logic [CNT_W-1:0] extra;
         logic [ATT_W:0]   sum;
         assign extra    = sat_cnt >> SAT_SHIFT;
         assign sum      = (ATT_W + 1)'(STEP_BIG) + (ATT_W + 1)'(extra);
         assign big_step = sum[ATT_W] ? '1 : sum[ATT_W-1:0];
      end
   endgenerate

   always_comb begin
      act  = ACT_HOLD;
      step = '0;
      if (sat_cnt != '0 && sat_cnt >= cfg_heavy_thr) begin
         act  = ACT_ATT_UP;
         step = big_step;
      end else if (sat_cnt != '0 || peak > cfg_win_hi) begin
         act  = ACT_ATT_UP;
         step = ATT_W'(STEP_SMALL);
      end else if (peak < cfg_win_lo) begin
         act  = ACT_ATT_DOWN;
         step = ATT_W'(STEP_SMALL);
      end else begin
         act  = ACT_LOCK;
      end
   end

endmodule

// File: rtl/agc_atten_acc.sv
module agc_atten_acc
   import agc_pkg::*;
#(
   parameter int ATT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [ATT_W-1:0] load_val,
   input  logic             act_vld,
   input  agc_act_e         act,
   input  logic [ATT_W-1:0] step,
   output logic [ATT_W-1:0] atten_q
);

   logic [ATT_W:0]   sum;
   logic [ATT_W-1:0] up_sat;
   logic [ATT_W-1:0] dn_sat;

   always_comb begin
      sum    = {1'b0, atten_q} + {1'b0, step};
      up_sat = sum[ATT_W] ? '1 : sum[ATT_W-1:0];
      dn_sat = (step > atten_q) ? '0 : (atten_q - step);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         atten_q <= '0;
      end else if (clr) begin
         atten_q <= '0;
      end else if (load) begin
         atten_q <= load_val;
      end else if (act_vld) begin
         case (act)
            ACT_ATT_UP:   atten_q <= up_sat;
            ACT_ATT_DOWN: atten_q <= dn_sat;
            default:      atten_q <= atten_q;
         endcase
      end
   end

   AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (act_vld && act == ACT_ATT_UP && !clr && !load) |=> atten_q >= $past(atten_q)); // R10
   AST_NO_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (act_vld && act == ACT_ATT_DOWN && !clr && !load) |=> atten_q <= $past(atten_q)); // R10

endmodule

// File: rtl/rx_agc_lock_ctrl.sv
module rx_agc_lock_ctrl
   import agc_pkg::*;
#(
   parameter  int ADC_W      = 8,
   parameter  int WIN        = 32,
   parameter  int ATT_W      = 6,
   parameter  int STEP_BIG   = 8,
   parameter  int STEP_SMALL = 2,
   parameter  int ADAPT_STEP = 0,
   parameter  int SAT_SHIFT  = 2,
   localparam int MAG_W      = ADC_W - 1,
   localparam int CNT_W      = $clog2(WIN + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    rx_en,
   input  logic                    smp_valid,
   input  logic signed [ADC_W-1:0] smp_data,
   input  logic                    pad_det,
   input  logic [MAG_W-1:0]        cfg_win_lo,
   input  logic [MAG_W-1:0]        cfg_win_hi,
   input  logic [CNT_W-1:0]        cfg_heavy_thr,
   input  logic [MAG_W-1:0]        cfg_unlock_delta,
   input  logic [ATT_W-1:0]        cfg_pad_preset,
   output logic [ATT_W-1:0]        gain_atten,
   output logic                    pad_on,
   output logic                    agc_locked,
   output logic                    cs_pulse
);

   initial begin : p_param_chk
      if (ADC_W < 3) $fatal(1, "ADC_W too small");
      if (WIN < 2 || (WIN & (WIN - 1)) != 0) $fatal(1, "WIN must be a power of two");
      if (ATT_W < 2) $fatal(1, "ATT_W too small");
      if (STEP_SMALL < 1 || STEP_BIG < STEP_SMALL) $fatal(1, "bad step sizes");
      if (STEP_BIG >= (1 << ATT_W)) $fatal(1, "STEP_BIG exceeds code range");
      if (ADAPT_STEP != 0 && ADAPT_STEP != 1) $fatal(1, "ADAPT_STEP is 0 or 1");
   end

   logic             win_done;
   logic [CNT_W-1:0] win_sat;
   logic [MAG_W-1:0] win_peak;
   agc_act_e         act;
   logic [ATT_W-1:0] step;
   logic             pad_take;
   logic             act_vld;
   logic             locked_q;
   logic             cs_q;
   logic             pad_q;
   logic [MAG_W-1:0] ref_q;
   logic [MAG_W-1:0] drift;

   assign pad_take = rx_en & pad_det & ~locked_q;
   assign act_vld  = rx_en & win_done & ~locked_q & ~pad_take;

   agc_window_meter #(
      .ADC_W (ADC_W),
      .WIN   (WIN)
   ) meter_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (~rx_en | pad_take),
      .smp_valid (smp_valid),
      .smp_data  (smp_data),
      .done_q    (win_done),
      .sat_q     (win_sat),
      .peak_q    (win_peak)
   );

   agc_step_sel #(
      .ADC_W      (ADC_W),
      .WIN        (WIN),
      .ATT_W      (ATT_W),
      .STEP_BIG   (STEP_BIG),
      .STEP_SMALL (STEP_SMALL),
      .ADAPT_STEP (ADAPT_STEP),
      .SAT_SHIFT  (SAT_SHIFT)
   ) step_i (
      .sat_cnt       (win_sat),
      .peak          (win_peak),
      .cfg_win_lo    (cfg_win_lo),
      .cfg_win_hi    (cfg_win_hi),
      .cfg_heavy_thr (cfg_heavy_thr),
      .act           (act),
      .step          (step)
   );

   agc_atten_acc #(
      .ATT_W (ATT_W)
   ) acc_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (~rx_en),
      .load     (pad_take),
      .load_val (cfg_pad_preset),
      .act_vld  (act_vld),
      .act      (act),
      .step     (step),
      .atten_q  (gain_atten)
   );

   assign drift = (win_peak > ref_q) ? (win_peak - ref_q) : (ref_q - win_peak);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         cs_q     <= 1'b0;
         pad_q    <= 1'b0;
         ref_q    <= '0;
      end else begin
         cs_q <= 1'b0;
         if (!rx_en) begin
            locked_q <= 1'b0;
            pad_q    <= 1'b0;
         end else if (pad_take) begin
            pad_q    <= 1'b1;
            locked_q <= 1'b0;
         end else if (win_done) begin
            if (!locked_q && act == ACT_LOCK) begin
               locked_q <= 1'b1;
               cs_q     <= 1'b1;
               ref_q    <= win_peak;
            end else if (locked_q && drift > cfg_unlock_delta) begin
               locked_q <= 1'b0;
            end
         end
      end
   end

   assign pad_on     = pad_q;
   assign agc_locked = locked_q;
   assign cs_pulse   = cs_q;

   AST_RESET_HOME: assert property (@(posedge clk)
      !rst_n |-> (gain_atten == '0 && !pad_on && !agc_locked && !cs_pulse)); // R1
   AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (agc_locked && rx_en) |=> $stable(gain_atten)); // R7
   AST_PAD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (agc_locked && rx_en) |=> $stable(pad_on)); // R9
   AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_pulse |=> !cs_pulse); // R6
   AST_CS_ON_LOCK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_pulse |-> (agc_locked && !$past(agc_locked))); // R6
   AST_RX_OFF_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> (gain_atten == '0 && !pad_on && !agc_locked)); // R11
   AST_PAD_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pad_on) |-> gain_atten == $past(cfg_pad_preset)); // R8

endmodule

// File: tb/rx_agc_lock_ctrl_tb.sv
`timescale 1ns/1ps
module rx_agc_lock_ctrl_tb_top;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rx_en = 1'b0;
   logic              smp_valid = 1'b0;
   logic signed [7:0] smp_data = '0;
   logic              pad_det = 1'b0;
   logic [6:0]        cfg_win_lo = 7'd40;
   logic [6:0]        cfg_win_hi = 7'd90;
   logic [5:0]        cfg_heavy_thr = 6'd8;
   logic [6:0]        cfg_unlock_delta = 7'd20;
   logic [5:0]        cfg_pad_preset = 6'd30;
   logic [5:0]        gain_atten;
   logic              pad_on;
   logic              agc_locked;
   logic              cs_pulse;

   int n_run  = 0;
   int n_fail = 0;
   int cs_seen = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   rx_agc_lock_ctrl dut_i (
      .clk              (clk),
      .rst_n            (rst_n),
      .rx_en            (rx_en),
      .smp_valid        (smp_valid),
      .smp_data         (smp_data),
      .pad_det          (pad_det),
      .cfg_win_lo       (cfg_win_lo),
      .cfg_win_hi       (cfg_win_hi),
      .cfg_heavy_thr    (cfg_heavy_thr),
      .cfg_unlock_delta (cfg_unlock_delta),
      .cfg_pad_preset   (cfg_pad_preset),
      .gain_atten       (gain_atten),
      .pad_on           (pad_on),
      .agc_locked       (agc_locked),
      .cs_pulse         (cs_pulse)
   );

   always @(negedge clk) if (cs_pulse) cs_seen++;

   // Window vectors: saturated samples, other amplitude, expected results
   localparam int NV = 10;
   localparam int V_NSAT [NV] = '{16, 16, 7, 0, 0, 0, 0, 20, 20, 0};
   localparam int V_AMP  [NV] = '{50, 50, 50, 100, 30, 40, 60, 60, 60, 90};
   localparam int V_ATT  [NV] = '{8, 16, 18, 20, 18, 18, 18, 18, 26, 26};
   localparam int V_LOCK [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 0, 1};
   localparam int V_CS   [NV] = '{0, 0, 0, 0, 0, 1, 0, 0, 0, 1};
   localparam string V_REQ [NV] = '{"R3", "R3", "R4", "R4", "R5", "R6", "R7", "R7", "R3", "R6"};

   task automatic check(input string req, input string what, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic feed_window(input int nsat, input int amp);
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         smp_valid = 1'b1;
         if (i < nsat) smp_data = (i % 2 == 0) ? 8'sd127 : -8'sd128;
         else          smp_data = (i % 2 == 0) ? 8'(amp) : 8'(-amp);
      end
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic pulse_pad();
      @(negedge clk); pad_det = 1'b1;
      @(negedge clk); pad_det = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic rx_cycle();
      @(negedge clk); rx_en = 1'b0;
      repeat (2) @(negedge clk);
      rx_en = 1'b1;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "atten", int'(gain_atten), 0);
      check("R1", "pad",   int'(pad_on), 0);
      check("R1", "lock",  int'(agc_locked), 0);
      check("R1", "cs",    int'(cs_pulse), 0);
      rst_n = 1'b1;
      rx_en = 1'b1;
      @(negedge clk);

      // R2 windowing underlies every vector below
      for (int v = 0; v < NV; v++) begin
         cs_seen = 0;
         feed_window(V_NSAT[v], V_AMP[v]);
         check(V_REQ[v], $sformatf("v%0d atten", v), int'(gain_atten), V_ATT[v]);
         check(V_REQ[v], $sformatf("v%0d lock", v),  int'(agc_locked), V_LOCK[v]);
         check(V_REQ[v], $sformatf("v%0d cs", v),    cs_seen, V_CS[v]);
      end

      // R9: pad request while locked is ignored
      pulse_pad();
      check("R9", "pad", int'(pad_on), 0);
      check("R9", "atten", int'(gain_atten), 26);
      check("R9", "lock", int'(agc_locked), 1);

      // R11: rx_en low returns home
      rx_cycle();
      check("R11", "atten", int'(gain_atten), 0);
      check("R11", "lock", int'(agc_locked), 0);
      check("R11", "pad", int'(pad_on), 0);

      // R8: pad while unlocked engages and preloads
      pulse_pad();
      check("R8", "pad", int'(pad_on), 1);
      check("R8", "atten", int'(gain_atten), 30);
      check("R8", "lock", int'(agc_locked), 0);

      // R3 at the threshold, then R10 upper clamp
      feed_window(8, 50);
      check("R3", "thr atten", int'(gain_atten), 38);
      feed_window(8, 50);
      feed_window(8, 50);
      feed_window(8, 50);
      check("R10", "near max", int'(gain_atten), 62);
      feed_window(8, 50);
      check("R10", "clamp max", int'(gain_atten), 63);
      check("R8", "pad held", int'(pad_on), 1);

      // R10 lower clamp
      rx_cycle();
      feed_window(0, 10);
      check("R10", "clamp min", int'(gain_atten), 0);
      check("R10", "lock", int'(agc_locked), 0);

      // R11: samples ignored with rx_en low, fresh window afterwards
      @(negedge clk); rx_en = 1'b0;
      feed_window(20, 50);
      check("R11", "ignored atten", int'(gain_atten), 0);
      check("R11", "ignored lock", int'(agc_locked), 0);
      rx_en = 1'b1;
      @(negedge clk);
      cs_seen = 0;
      feed_window(0, 60);
      check("R11", "fresh lock", int'(agc_locked), 1);
      check("R6", "fresh cs", cs_seen, 1);
      check("R6", "fresh atten", int'(gain_atten), 0);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule